// File: doc/BRIEF.md
# Serial-Bus PHY Control and Status Register File

This block is the register file on the PHY side of a multi-port serial bus node. Software reaches it through a port with a 4-bit address and 8-bit data. Writes take effect on a clock edge. Reads are combinational from the address.

The file holds the node configuration that feeds the self-identification packet:
- a link-on bit, gated by the external link power status input before it leaves the block;
- a contender bit;
- a 3-bit power class.

Four sticky event flags gather hardware events:
- loop seen;
- cable power lost;
- arbitration timeout;
- port event.

Each flag is cleared by writing one to it. Together the flags drive a single interrupt output. One control bit, when written with one, raises a single-cycle request to arbitrate for a short bus reset and never reads back as one.

Addresses 8 to 15 form a window. A page select and a port select choose what appears there. Page 0 is per-port: it shows the status of the selected port and that port's interrupt-enable bit. All other pages, and any port number at or above the port count, read as zero.

Top module: `phy_ctrl_regs`

## Requirements
- R1: After reset, the link-on bit (address 0 bit 7) is 1. Every other writable field reads 0, and every sticky flag reads 0.
- R2: `sidLinkBit` equals the link-on bit ANDed with `lpsIn`.
- R3: The contender bit (address 0 bit 6) and the power class (address 0 bits 5:3) are read/write. They drive `sidContender` and `sidPwrClass` directly.
- R4: Writing 1 to address 1 bit 0 makes `shortResetReq` high for exactly the one cycle after the write edge. That bit always reads back as 0.
- R5: The flags sit at address 2: bit 3 loop, bit 2 power fail, bit 1 timeout, bit 0 port event. A `loopDetect` or `arbTimeout` pulse sets its flag. Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged.
- R6: The power-fail flag sets when `cablePwr` goes from 1 to 0, and not on a 0-to-1 change.
- R7: When a hardware set and a write-one clear reach the same flag in the same cycle, the flag ends up set.
- R8: A change in connected, bias, disabled or fault status on a port sets the port-event flag only if that port's interrupt-enable bit is 1.
- R9: A `portResume` pulse on any port sets the port-event flag only if the resume-interrupt enable (address 1 bit 3) is 1.
- R10: Address 3 holds the page select in bits 7:5 and the port select in bits 3:0. With page 0 chosen, address 8 reads the selected port's status as {connected, bias, disabled, fault, 000, intEnable}, and bit 0 of that address is writable.
- R11: Addresses 4 to 7, addresses 9 to 15, pages 1 to 7, and port selects at or above the port count all read 0, and writes to them have no effect.
- R12: The acceleration enable (address 1 bit 2) and the multi-speed enable (address 1 bit 1) are read/write and drive `accelEn` and `multiEn`. The delay constant (address 1 bits 7:4) and the jitter constant (address 0 bits 2:0) are read-only.
- R13: `irqOut` is 1 exactly when at least one sticky flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regAddr | input | 4 | Register address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr |
| lpsIn | input | 1 | Link power status |
| cablePwr | input | 1 | Cable power present |
| loopDetect | input | 1 | Loop event pulse |
| arbTimeout | input | 1 | Arbitration timeout pulse |
| portConn | input | NUM_PORTS | Per-port connected status |
| portBias | input | NUM_PORTS | Per-port bias status |
| portDis | input | NUM_PORTS | Per-port disabled status |
| portFault | input | NUM_PORTS | Per-port fault status |
| portResume | input | NUM_PORTS | Per-port resume-start pulse |
| sidLinkBit | output | 1 | L bit for the self-ID packet |
| sidContender | output | 1 | C bit for the self-ID packet |
| sidPwrClass | output | 3 | Power field for the self-ID packet |
| shortResetReq | output | 1 | One-cycle short bus reset request |
| accelEn | output | 1 | Arbitration acceleration enable |
| multiEn | output | 1 | Multi-speed concatenation enable |
| irqOut | output | 1 | OR of the sticky flags |

## Verification
The bench drives a loop pulse in the same cycle as a write-one clear of the loop flag. A design that lets the clear win would drop that event.

It raises cable power and later lowers it. A detector that fires on either edge, or that misses the fall, shows up at once.

It toggles status on a port whose interrupt enable is 0, and pulses resume with the resume enable off. Both must leave the port-event flag clear; a flag that sets anyway means the gating is missing.

It checks that the reset request lasts one cycle and reads back 0. It also checks that out-of-range ports, unused pages and unused addresses read zero, which exposes a window decoder that aliases or wraps.

// File: rtl/phy_reg_pkg.sv
package phy_reg_pkg;

  typedef enum logic [2:0] {
    RD_CFG0, RD_CFG1, RD_FLAGS, RD_SEL, RD_PORT, RD_ZERO
  } rdSel_e;

  typedef struct packed {
    logic   wrCfg0;
    logic   wrCfg1;
    logic   wrFlags;
    logic   wrSel;
    logic   wrPort;
    rdSel_e rdSel;
  } regStrobe_t;

  localparam int FLAG_LOOP    = 3;
  localparam int FLAG_PWRFAIL = 2;
  localparam int FLAG_TIMEOUT = 1;
  localparam int FLAG_PORTEVT = 0;

endpackage

// File: rtl/phy_reg_ctrl.sv
module phy_reg_ctrl
  import phy_reg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int PAGE_W = 3
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [PAGE_W-1:0] pageSel,
  output regStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(8);

  logic portHit;

  // The per-port view is reachable only at the first window slot of page 0.
  assign portHit = (regAddr == WIN_BASE) && (pageSel == '0);

  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_ZERO;
    unique case (regAddr)
      ADDR_W'(0): begin strobe.wrCfg0  = regWrEn; strobe.rdSel = RD_CFG0;  end
      ADDR_W'(1): begin strobe.wrCfg1  = regWrEn; strobe.rdSel = RD_CFG1;  end
      ADDR_W'(2): begin strobe.wrFlags = regWrEn; strobe.rdSel = RD_FLAGS; end
      ADDR_W'(3): begin strobe.wrSel   = regWrEn; strobe.rdSel = RD_SEL;   end
      default: begin
        if (portHit) begin
          strobe.wrPort = regWrEn;
          strobe.rdSel  = RD_PORT;
        end
      end
    endcase
  end

endmodule

// File: rtl/phy_reg_data.sv
module phy_reg_data
  import phy_reg_pkg::*;
#(
  parameter int          NUM_PORTS  = 3,
  parameter int          PAGE_W     = 3,
  parameter int          PORT_W     = 4,
  parameter logic [3:0]  DELAY_VAL  = 4'd5,
  parameter logic [2:0]  JITTER_VAL = 3'd2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strobe,
  input  logic [7:0]           wrData,
  input  logic                 cablePwr,
  input  logic                 loopDetect,
  input  logic                 arbTimeout,
  input  logic [NUM_PORTS-1:0] portConn,
  input  logic [NUM_PORTS-1:0] portBias,
  input  logic [NUM_PORTS-1:0] portDis,
  input  logic [NUM_PORTS-1:0] portFault,
  input  logic [NUM_PORTS-1:0] portResume,
  output logic                 linkOn,
  output logic                 contender,
  output logic [2:0]           pwrClass,
  output logic                 accelEn,
  output logic                 multiEn,
  output logic                 resetReq,
  output logic [3:0]           flags,
  output logic [PAGE_W-1:0]    pageSel,
  output logic [7:0]           rdData
);

  logic              resumeIrqEn;
  logic [PORT_W-1:0] portSel;
  logic              cablePwrQ;
  logic              pastValid;

  logic [NUM_PORTS-1:0] intEn;
  logic [NUM_PORTS-1:0] statChg;
  logic [3:0]           statNow  [NUM_PORTS];
  logic [3:0]           statPrev [NUM_PORTS];

  // Per-port status history, change detection and interrupt enables.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign statNow[p] = {portConn[p], portBias[p], portDis[p], portFault[p]};
    assign statChg[p] = statNow[p] != statPrev[p];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statPrev[p] <= '0;
        intEn[p]    <= 1'b0;
      end else begin
        statPrev[p] <= statNow[p];
        if (strobe.wrPort && portSel == PORT_W'(p)) intEn[p] <= wrData[0];
      end
    end
  end

  logic       pwrFall;
  logic       portEvtSet;
  logic [3:0] setVec;
  logic [3:0] clrVec;

  assign pwrFall    = cablePwrQ & ~cablePwr;
  assign portEvtSet = |(statChg & intEn) | (resumeIrqEn & |portResume);

  always_comb begin
    setVec               = '0;
    setVec[FLAG_LOOP]    = loopDetect;
    setVec[FLAG_PWRFAIL] = pwrFall;
    setVec[FLAG_TIMEOUT] = arbTimeout;
    setVec[FLAG_PORTEVT] = portEvtSet;
    clrVec = strobe.wrFlags ? wrData[3:0] : 4'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linkOn      <= 1'b1;
      contender   <= 1'b0;
      pwrClass    <= '0;
      accelEn     <= 1'b0;
      multiEn     <= 1'b0;
      resumeIrqEn <= 1'b0;
      resetReq    <= 1'b0;
      flags       <= '0;
      pageSel     <= '0;
      portSel     <= '0;
      cablePwrQ   <= 1'b0;
      pastValid   <= 1'b0;
    end else begin
      pastValid <= 1'b1;
      cablePwrQ <= cablePwr;
      resetReq  <= strobe.wrCfg1 & wrData[0];
      // A set in the same cycle as a clear leaves the flag set.
      flags     <= (flags & ~clrVec) | setVec;
      if (strobe.wrCfg0) begin
        linkOn    <= wrData[7];
        contender <= wrData[6];
        pwrClass  <= wrData[5:3];
      end
      if (strobe.wrCfg1) begin
        resumeIrqEn <= wrData[3];
        accelEn     <= wrData[2];
        multiEn     <= wrData[1];
      end
      if (strobe.wrSel) begin
        pageSel <= wrData[7:5];
        portSel <= wrData[PORT_W-1:0];
      end
    end
  end

  // Read path.
  logic [7:0] portByte;

  always_comb begin
    portByte = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (portSel == PORT_W'(p)) portByte = {statNow[p], 3'b000, intEn[p]};
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_CFG0:  rdData = {linkOn, contender, pwrClass, JITTER_VAL};
      RD_CFG1:  rdData = {DELAY_VAL, resumeIrqEn, accelEn, multiEn, 1'b0};
      RD_FLAGS: rdData = {4'b0, flags};
      RD_SEL:   rdData = {pageSel, 1'b0, 4'(portSel)};
      RD_PORT:  rdData = portByte;
      default:  rdData = '0;
    endcase
  end

  // Assertions next to the logic they guard.
  p_req_one_cycle_r4: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(loopDetect) && $past(rstN)) |-> flags[FLAG_LOOP]);

  p_pwr_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(cablePwrQ && !cablePwr) && $past(rstN)) |-> flags[FLAG_PWRFAIL]);

  p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(strobe.wrSel)) |-> $stable(pageSel));

endmodule

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs
  import phy_reg_pkg::*;
#(
  parameter int         NUM_PORTS  = 3,
  parameter logic [3:0] DELAY_VAL  = 4'd5,
  parameter logic [2:0] JITTER_VAL = 3'd2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [3:0]           regAddr,
  input  logic                 regWrEn,
  input  logic [7:0]           regWrData,
  output logic [7:0]           regRdData,
  input  logic                 lpsIn,
  input  logic                 cablePwr,
  input  logic                 loopDetect,
  input  logic                 arbTimeout,
  input  logic [NUM_PORTS-1:0] portConn,
  input  logic [NUM_PORTS-1:0] portBias,
  input  logic [NUM_PORTS-1:0] portDis,
  input  logic [NUM_PORTS-1:0] portFault,
  input  logic [NUM_PORTS-1:0] portResume,
  output logic                 sidLinkBit,
  output logic                 sidContender,
  output logic [2:0]           sidPwrClass,
  output logic                 shortResetReq,
  output logic                 accelEn,
  output logic                 multiEn,
  output logic                 irqOut
);

  localparam int ADDR_W = 4;
  localparam int PAGE_W = 3;
  localparam int PORT_W = 4;

  regStrobe_t        strobe;
  logic [PAGE_W-1:0] pageSel;
  logic              linkOn;
  logic [3:0]        flags;

  phy_reg_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .pageSel (pageSel),
    .strobe  (strobe)
  );

  phy_reg_data #(
    .NUM_PORTS(NUM_PORTS), .PAGE_W(PAGE_W), .PORT_W(PORT_W),
    .DELAY_VAL(DELAY_VAL), .JITTER_VAL(JITTER_VAL)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (regWrData),
    .cablePwr   (cablePwr),
    .loopDetect (loopDetect),
    .arbTimeout (arbTimeout),
    .portConn   (portConn),
    .portBias   (portBias),
    .portDis    (portDis),
    .portFault  (portFault),
    .portResume (portResume),
    .linkOn     (linkOn),
    .contender  (sidContender),
    .pwrClass   (sidPwrClass),
    .accelEn    (accelEn),
    .multiEn    (multiEn),
    .resetReq   (shortResetReq),
    .flags      (flags),
    .pageSel    (pageSel),
    .rdData     (regRdData)
  );

  assign sidLinkBit = linkOn & lpsIn;
  assign irqOut     = |flags;

  // The reset request bit never reads back as one.
  p_req_reads_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 4'd1) |-> !regRdData[0]);

endmodule

// File: tb/phy_ctrl_regs_bench.sv
`timescale 1ns/1ps
module phy_ctrl_regs_bench;

  localparam int NP = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [3:0]    regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [7:0]    regWrData = '0;
  logic [7:0]    regRdData;
  logic          lpsIn = 1'b1;
  logic          cablePwr = 1'b0;
  logic          loopDetect = 1'b0;
  logic          arbTimeout = 1'b0;
  logic [NP-1:0] portConn = '0, portBias = '0, portDis = '0, portFault = '0, portResume = '0;
  logic          sidLinkBit, sidContender, shortResetReq, accelEn, multiEn, irqOut;
  logic [2:0]    sidPwrClass;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  phy_ctrl_regs #(.NUM_PORTS(NP), .DELAY_VAL(4'd5), .JITTER_VAL(3'd2)) u_phy_ctrl_regs (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a; regWrEn = 1'b0;
    #1 v = regRdData;
  endtask

  task automatic test_reset();
    logic [7:0] v;
    rd(4'd0, v); chk("R1 cfg0", v, 8'h82);
    rd(4'd1, v); chk("R1 cfg1 / R12 delay", v, 8'h50);
    rd(4'd2, v); chk("R1 flags", v, 8'h00);
    rd(4'd3, v); chk("R1 select", v, 8'h00);
    chk("R13 irq idle", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic test_selfid();
    logic [7:0] v;
    chk("R2 L with lps", {7'b0, sidLinkBit}, 8'h01);
    @(negedge clk); lpsIn = 1'b0; #1;
    chk("R2 L gated", {7'b0, sidLinkBit}, 8'h00);
    lpsIn = 1'b1;
    wr(4'd0, 8'h6F);               // link 0, contender 1, class 101, jitter bits ignored
    rd(4'd0, v); chk("R3 cfg0 rw / R12 jitter RO", v, 8'h6A);
    chk("R3 contender", {7'b0, sidContender}, 8'h01);
    chk("R3 pwrClass", {5'b0, sidPwrClass}, 8'h05);
    chk("R2 L after link cleared", {7'b0, sidLinkBit}, 8'h00);
  endtask

  task automatic test_enables();
    logic [7:0] v;
    wr(4'd1, 8'hF6);               // accel, multi; delay bits ignored
    rd(4'd1, v); chk("R12 cfg1", v, 8'h56);
    chk("R12 outputs", {6'b0, accelEn, multiEn}, 8'h03);
    wr(4'd1, 8'h00);
  endtask

  task automatic test_short_reset();
    logic [7:0] v;
    wr(4'd1, 8'h01);
    chk("R4 req high", {7'b0, shortResetReq}, 8'h01);
    @(negedge clk);
    chk("R4 req one cycle", {7'b0, shortResetReq}, 8'h00);
    rd(4'd1, v); chk("R4 reads zero", v, 8'h50);
  endtask

  task automatic test_flags();
    logic [7:0] v;
    @(negedge clk); arbTimeout = 1'b1;
    @(negedge clk); arbTimeout = 1'b0;
    rd(4'd2, v); chk("R5 timeout set", v, 8'h02);
    chk("R13 irq set", {7'b0, irqOut}, 8'h01);
    wr(4'd2, 8'h00);
    rd(4'd2, v); chk("R5 write zero no effect", v, 8'h02);
    wr(4'd2, 8'h02);
    rd(4'd2, v); chk("R5 w1c", v, 8'h00);
    chk("R13 irq clear", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic test_set_wins();
    logic [7:0] v;
    @(negedge clk); loopDetect = 1'b1;
    @(negedge clk); loopDetect = 1'b0;
    rd(4'd2, v); chk("R5 loop set", v, 8'h08);
    @(negedge clk);
    regAddr = 4'd2; regWrData = 8'h08; regWrEn = 1'b1; loopDetect = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; loopDetect = 1'b0;
    rd(4'd2, v); chk("R7 set wins", v, 8'h08);
    wr(4'd2, 8'h08);
    rd(4'd2, v); chk("R7 later clear", v, 8'h00);
  endtask

  task automatic test_pwr_fail();
    logic [7:0] v;
    @(negedge clk); cablePwr = 1'b1;
    repeat (2) @(negedge clk);
    rd(4'd2, v); chk("R6 rise ignored", v, 8'h00);
    @(negedge clk); cablePwr = 1'b0;
    rd(4'd2, v); chk("R6 fall sets", v, 8'h04);
    wr(4'd2, 8'h04);
  endtask

  task automatic test_ports();
    logic [7:0] v;
    wr(4'd3, 8'h01);               // page 0, port 1
    wr(4'd8, 8'h01);               // intEnable for port 1
    rd(4'd8, v); chk("R10 port1 window", v, 8'h01);
    @(negedge clk); portBias[0] = 1'b1;
    repeat (2) @(negedge clk);
    rd(4'd2, v); chk("R8 no event without enable", v, 8'h00);
    @(negedge clk); portBias[1] = 1'b1; portFault[1] = 1'b1;
    rd(4'd2, v); chk("R8 enabled change", v, 8'h01);
    rd(4'd8, v); chk("R10 port1 status", v, 8'h51);
    wr(4'd2, 8'h01);
    wr(4'd3, 8'h00);
    rd(4'd8, v); chk("R10 port0 status", v, 8'h40);
    rd(4'd3, v); chk("R10 select readback", v, 8'h00);
  endtask

  task automatic test_resume();
    logic [7:0] v;
    @(negedge clk); portResume[2] = 1'b1;
    @(negedge clk); portResume[2] = 1'b0;
    rd(4'd2, v); chk("R9 resume masked", v, 8'h00);
    wr(4'd1, 8'h08);
    @(negedge clk); portResume[2] = 1'b1;
    @(negedge clk); portResume[2] = 1'b0;
    rd(4'd2, v); chk("R9 resume enabled", v, 8'h01);
    wr(4'd2, 8'h01);
    wr(4'd1, 8'h00);
  endtask

  task automatic test_unimpl();
    logic [7:0] v;
    wr(4'd5, 8'hFF);
    rd(4'd5, v); chk("R11 addr5", v, 8'h00);
    wr(4'd3, 8'h00);
    wr(4'd9, 8'hFF);
    rd(4'd9, v); chk("R11 addr9 page0", v, 8'h00);
    wr(4'd3, 8'h03);               // port 3 is out of range
    wr(4'd8, 8'hFF);
    rd(4'd8, v); chk("R11 port out of range", v, 8'h00);
    wr(4'd3, 8'h21);               // page 1, port 1
    wr(4'd8, 8'h00);
    rd(4'd8, v); chk("R11 page1", v, 8'h00);
    wr(4'd3, 8'h01);
    rd(4'd8, v); chk("R11 page1 write ignored", v, 8'h51);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_selfid();
    test_enables();
    test_short_reset();
    test_flags();
    test_set_wins();
    test_pwr_fail();
    test_ports();
    test_resume();
    test_unimpl();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule